// File: doc/BRIEF.md
# Packed Byte Compare-to-Mask Unit

This unit compares two packed vectors of 8-bit elements lane by lane and writes one result bit per lane into a mask. The operands are 512 bits wide. A two-bit length select sets how many low lanes take part: 16, 32 or 64. A sign select chooses whether each byte is read as a two's-complement value or as an unsigned value from 0 to 255. The low three bits of an 8-bit predicate code choose the relation. An optional enable mask forces chosen lanes to zero. Result bits above the active lane count are always cleared.

The inputs are captured on a rising clock edge while `in_valid` is high, and the mask appears at the next edge. A two-state control machine tracks the output. `ST_IDLE` means no fresh result is held. `ST_VALID` means the result register was loaded at the last edge. The transition IDLE→VALID or VALID→VALID (named *load*) is taken whenever `in_valid` is high. The transition VALID→IDLE or IDLE→IDLE (named *drain*) is taken when it is low. Reset forces `ST_IDLE`. The output register keeps its last value during *drain*.

Top module: `byte_cmp_mask`

## Requirements
- R1: The length select `vlen_sel` gives the active lane count. Code 0 gives 16 lanes, code 1 gives 32 lanes, and codes 2 and 3 give all 64 lanes. Every result bit at or above the active count is 0.
- R2: Lane j compares `src_a[8j+7:8j]` with `src_b[8j+7:8j]`. The relation is evaluated as a OP b, and the outcome of lane j goes to result bit j.
- R3: Predicate codes `pred[2:0]` select the relation: 0 is a==b, 1 is a<b, 2 is a<=b, 4 is a!=b, 5 is a>=b and 6 is a>b.
- R4: Predicate code 3 gives 0 in every lane. Predicate code 7 gives 1 in every active, enabled lane.
- R5: `pred[7:3]` has no effect on the result.
- R6: With `is_signed`=1 each byte is two's complement, so 0x80 is the smallest value and 0x7F is the largest. With `is_signed`=0 each byte is unsigned, so 0x00 is the smallest value and 0xFF is the largest.
- R7: When `wmask_en`=1 and `wmask[j]`=0, result bit j is 0. It is zeroed, not kept from a previous result.
- R8: When `wmask_en`=0, every active lane is evaluated, whatever value `wmask` has.
- R9: A high `in_valid` at a rising edge loads the result, and `out_valid` is 1 in the following cycle. When `in_valid` is low, `out_valid` drops and `mask_out` holds its value.
- R10: A synchronous active-high `rst` clears `mask_out` to 0 and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Load strobe for the operands |
| src_a | input | 512 | Left operand, 64 packed bytes |
| src_b | input | 512 | Right operand, 64 packed bytes |
| vlen_sel | input | 2 | Active length: 0=16, 1=32, 2/3=64 lanes |
| is_signed | input | 1 | 1 = two's-complement bytes, 0 = unsigned bytes |
| pred | input | 8 | Predicate code; only bits 2:0 are used |
| wmask | input | 64 | Per-lane enable used for zeroing |
| wmask_en | input | 1 | 1 = apply `wmask` |
| out_valid | output | 1 | Result loaded at the last edge |
| mask_out | output | 64 | Registered per-lane result |

## Verification
Properties check the following on every loaded result:
- the upper bits are cleared for the 16-lane and 32-lane lengths;
- no bit survives where the enable mask was 0;
- code 3 yields an all-zero mask and code 7 a full mask;
- the valid timing and the hold behaviour;
- the reset values.

Only the bench scenarios can show the actual ordering of each relation. They cover the boundary bytes 0x00, 0x7F, 0x80 and 0xFF in both sign modes, the per-lane byte positions, and that the reserved predicate bits are ignored.

// File: rtl/byte_cmp_pkg.sv
package byte_cmp_pkg;

    typedef enum logic [2:0] {
        CC_EQ     = 3'd0,
        CC_LT     = 3'd1,
        CC_LE     = 3'd2,
        CC_NEVER  = 3'd3,
        CC_NE     = 3'd4,
        CC_GE     = 3'd5,
        CC_GT     = 3'd6,
        CC_ALWAYS = 3'd7
    } cmp_code_e;

    typedef enum logic [1:0] {
        VL_QUARTER = 2'd0,
        VL_HALF    = 2'd1,
        VL_FULL    = 2'd2,
        VL_FULL_X  = 2'd3
    } vlen_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } out_state_e;

endpackage

// File: rtl/byte_lane_cmp.sv
module byte_lane_cmp
    import byte_cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    input  cmp_code_e    code,
    output logic         hit
);
    // one extra bit: sign copy when signed, zero when unsigned
    logic signed [W:0] ax;
    logic signed [W:0] bx;
    logic              eq;
    logic              lt;
    logic              base;

    always_comb begin
        ax = {is_signed & a[W-1], a};
        bx = {is_signed & b[W-1], b};
        eq = (ax == bx);
        lt = (ax < bx);
        unique case (code[1:0])
            2'd0:    base = eq;
            2'd1:    base = lt;
            2'd2:    base = lt | eq;
            default: base = 1'b0;
        endcase
        // the upper half of the code set negates the lower half
        hit = base ^ code[2];
    end

endmodule

// File: rtl/lane_gate.sv
module lane_gate
    import byte_cmp_pkg::*;
#(
    parameter int LANES = 64
) (
    input  vlen_e              vlen,
    input  logic [LANES-1:0]   wmask,
    input  logic               wmask_en,
    output logic [LANES-1:0]   lane_en
);
    localparam int CW = $clog2(LANES + 1);

    logic [CW-1:0] n_active;

    always_comb begin
        unique case (vlen)
            VL_QUARTER: n_active = CW'(LANES / 4);
            VL_HALF:    n_active = CW'(LANES / 2);
            default:    n_active = CW'(LANES);
        endcase
    end

    for (genvar j = 0; j < LANES; j++) begin : g_gate
        assign lane_en[j] = (CW'(j) < n_active) & (~wmask_en | wmask[j]);
    end

endmodule

// File: rtl/byte_cmp_mask.sv
module byte_cmp_mask
    import byte_cmp_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 64,
    parameter int VEC_W  = LANE_W * LANES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic [1:0]         vlen_sel,
    input  logic               is_signed,
    input  logic [7:0]         pred,
    input  logic [LANES-1:0]   wmask,
    input  logic               wmask_en,
    output logic               out_valid,
    output logic [LANES-1:0]   mask_out
);
    localparam int Q = LANES / 4;
    localparam int H = LANES / 2;

    cmp_code_e        code;
    logic [LANES-1:0] hits;
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] result_d;
    logic [LANES-1:0] mask_q;
    logic             unused_pred_hi;
    out_state_e       state_q;
    out_state_e       state_d;

    assign code           = cmp_code_e'(pred[2:0]);
    assign unused_pred_hi = ^pred[7:3];   // reserved bits (R5)

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        byte_lane_cmp #(.W(LANE_W)) u_cmp (
            .a         (src_a[j*LANE_W +: LANE_W]),
            .b         (src_b[j*LANE_W +: LANE_W]),
            .is_signed (is_signed),
            .code      (code),
            .hit       (hits[j])
        );
    end

    lane_gate #(.LANES(LANES)) u_gate (
        .vlen     (vlen_e'(vlen_sel)),
        .wmask    (wmask),
        .wmask_en (wmask_en),
        .lane_en  (lane_en)
    );

    assign result_d = hits & lane_en;

    // next-state: load on strobe, drain otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) mask_q <= result_d;
        end
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_VALID);
        mask_out  = mask_q;
    end

    // ---------------- assertions ----------------
    p_len_quarter_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(vlen_sel) == 2'd0 |-> mask_out[LANES-1:Q] == '0);

    p_len_half_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(vlen_sel) == 2'd1 |-> mask_out[LANES-1:H] == '0);

    p_never_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(pred[2:0]) == 3'd3 |-> mask_out == '0);

    p_always_full_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(pred[2:0]) == 3'd7 && !$past(wmask_en)
        && $past(vlen_sel) >= 2'd2 |-> &mask_out);

    p_zeroing_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(wmask_en) |-> (mask_out & ~$past(wmask)) == '0);

    p_load_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(mask_out));

    p_reset_r10: assert property (@(posedge clk)
        rst |=> !out_valid && mask_out == '0);

endmodule

// File: tb/byte_cmp_mask_bench.sv
module byte_cmp_mask_bench;
    localparam int LANES = 64;
    localparam int VEC_W = 512;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [VEC_W-1:0] src_a;
    logic [VEC_W-1:0] src_b;
    logic [1:0]       vlen_sel;
    logic             is_signed;
    logic [7:0]       pred;
    logic [LANES-1:0] wmask;
    logic             wmask_en;
    logic             out_valid;
    logic [LANES-1:0] mask_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    byte_cmp_mask u_byte_cmp_mask (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .vlen_sel(vlen_sel),
        .is_signed(is_signed), .pred(pred), .wmask(wmask),
        .wmask_en(wmask_en), .out_valid(out_valid), .mask_out(mask_out)
    );

    // {a, b, signed, code, expected}: broadcast to all 64 lanes
    localparam int NV = 18;
    localparam logic [20:0] VEC [NV] = '{
        {8'h7F, 8'h80, 1'b1, 3'd1, 1'b0},
        {8'h7F, 8'h80, 1'b0, 3'd1, 1'b1},
        {8'h80, 8'h7F, 1'b1, 3'd1, 1'b1},
        {8'h80, 8'h7F, 1'b0, 3'd1, 1'b0},
        {8'h00, 8'hFF, 1'b1, 3'd6, 1'b1},
        {8'h00, 8'hFF, 1'b0, 3'd6, 1'b0},
        {8'hFF, 8'hFF, 1'b0, 3'd0, 1'b1},
        {8'hFF, 8'hFF, 1'b1, 3'd2, 1'b1},
        {8'hFF, 8'h00, 1'b1, 3'd2, 1'b1},
        {8'hFF, 8'h00, 1'b0, 3'd2, 1'b0},
        {8'h80, 8'h80, 1'b1, 3'd4, 1'b0},
        {8'h00, 8'h7F, 1'b0, 3'd4, 1'b1},
        {8'h7F, 8'h00, 1'b1, 3'd5, 1'b1},
        {8'h00, 8'h7F, 1'b1, 3'd5, 1'b0},
        {8'h80, 8'h00, 1'b0, 3'd3, 1'b0},
        {8'h00, 8'h80, 1'b1, 3'd7, 1'b1},
        {8'h80, 8'h00, 1'b1, 3'd6, 1'b0},
        {8'hFF, 8'h80, 1'b0, 3'd5, 1'b1}
    };

    task automatic check(input string req, input logic [LANES-1:0] act,
                         input logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, strobe once, sample at the following negedge
    task automatic apply(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                         input logic [1:0] vl, input logic sg, input logic [7:0] p,
                         input logic [LANES-1:0] wm, input logic wme);
        @(negedge clk);
        src_a = a; src_b = b; vlen_sel = vl; is_signed = sg;
        pred = p; wmask = wm; wmask_en = wme; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [VEC_W-1:0] ramp;
        rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; vlen_sel = 2'd2;
        is_signed = 1'b0; pred = 8'h07; wmask = '0; wmask_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset mask", mask_out, '0);
        check("R10 reset valid", {63'd0, out_valid}, '0);
        rst = 1'b0;

        // R3 R6 R4: vector table across boundary bytes
        for (int i = 0; i < NV; i++) begin
            apply({64{VEC[i][20:13]}}, {64{VEC[i][12:5]}}, 2'd2, VEC[i][4],
                  {5'd0, VEC[i][3:1]}, '0, 1'b0);
            check($sformatf("R3/R6 vector %0d", i), mask_out, {64{VEC[i][0]}});
        end
        check("R9 valid after load", {63'd0, out_valid}, 64'd1);

        // R2: lane j holds byte j, compared unsigned with 5 using a<b
        for (int j = 0; j < LANES; j++) ramp[j*8 +: 8] = 8'(j);
        apply(ramp, {64{8'd5}}, 2'd2, 1'b0, 8'd1, '0, 1'b0);
        check("R2 lane positions lt", mask_out, 64'h1F);

        // R1: 32 lanes, a>b against 20, lanes above 31 cleared
        apply(ramp, {64{8'd20}}, 2'd1, 1'b0, 8'd6, '0, 1'b0);
        check("R1 half length", mask_out, 64'hFFE0_0000);
        apply('0, '0, 2'd0, 1'b0, 8'd7, '0, 1'b0);
        check("R1 quarter length", mask_out, 64'h0000_0000_0000_FFFF);
        apply('0, '0, 2'd3, 1'b0, 8'd7, '0, 1'b0);
        check("R1 code 3 full length", mask_out, '1);

        // R7: zeroing mask, R8: mask ignored when disabled
        apply('0, '0, 2'd2, 1'b0, 8'd7, 64'hF0F0_0000_1234_5678, 1'b1);
        check("R7 zeroing", mask_out, 64'hF0F0_0000_1234_5678);
        apply('0, '0, 2'd2, 1'b1, 8'd0, '0, 1'b0);
        check("R8 mask unused", mask_out, '1);

        // R5: reserved predicate bits
        apply('0, {64{8'h01}}, 2'd2, 1'b0, 8'hF9, '0, 1'b0);
        check("R5 reserved set lt", mask_out, '1);
        apply('0, {64{8'h01}}, 2'd2, 1'b0, 8'h78, '0, 1'b0);
        check("R5 reserved set eq", mask_out, '0);

        // R9: hold while strobe low
        apply('0, '0, 2'd2, 1'b0, 8'd7, 64'hAAAA, 1'b1);
        src_a = '1; pred = 8'd3;
        @(negedge clk);
        check("R9 hold mask", mask_out, 64'hAAAA);
        check("R9 valid drops", {63'd0, out_valid}, '0);

        // R10: reset after a result
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset clears result", mask_out, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule